// File: doc/BRIEF.md
# Failure Flag Collector with Rate-Limited Interrupt

The block gathers four independent failure indications from line-driver and receiver diagnostics into one 4-bit status register. Each indication is an asynchronous level, so it is synchronized before use. Software can sample the register with a read strobe at any time, whatever the interrupt state.

Any change of any status bit is an event. Both a new failure and a recovery count. When interrupts are enabled, an event raises a level interrupt that stays high until software clears it. The block issues at most one interrupt per watchdog period. A pulse marks the start of each period. An event that arrives after the period's interrupt has been used is held pending and is issued when the next period starts. The block also registers a ground-shift threshold select bit and passes it to the analog detector.

Top module: `fault_flag_irq`

## Requirements
- R1: After reset, irq_o, rd_data_o and gnd_lvl_o are 0, and the status register holds 0.
- R2: Status bits map as bit 0 bus wiring fault, bit 1 receive-data pin fault, bit 2 transmit-data pin fault, bit 3 ground shift. Each input passes through a two-flop synchronizer and then the status register.
- R3: A rising or a falling change of any status bit is one event. Changes of several bits in the same cycle form a single event.
- R4: With irq_en_i low, events are discarded and any pending event is dropped. Raising irq_en_i later brings no interrupt for them.
- R5: With the period budget unused and interrupts enabled, irq_o rises at the 4th rising clock edge after a flags_i change. At most one interrupt is issued between two period_start_i pulses.
- R6: An event suppressed by the rate limit stays pending. It sets irq_o at the clock edge where period_start_i is high, and that interrupt uses the new period's budget.
- R7: irq_o stays high until a cycle with irq_clr_i high. If a new interrupt is issued in that same cycle, the set wins.
- R8: rd_data_o takes the status register value on each edge with rd_i high and holds its value otherwise. The register can be read whatever the interrupt state.
- R9: gnd_lvl_o follows gnd_lvl_sel_i one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flags_i | input | 4 | Raw failure indications (asynchronous) |
| irq_en_i | input | 1 | Interrupt enable |
| period_start_i | input | 1 | One-cycle pulse at each watchdog period start |
| irq_clr_i | input | 1 | Interrupt clear strobe |
| rd_i | input | 1 | Status read strobe |
| rd_data_o | output | 4 | Captured status value |
| irq_o | output | 1 | Level interrupt request |
| gnd_lvl_sel_i | input | 1 | Ground-shift threshold select |
| gnd_lvl_o | output | 1 | Registered threshold select for the detector |

## Verification
The bench first drives a single rising bit to measure the exact synchronizer and edge-detect latency. It then drives a falling bit to show that recovery raises an interrupt as well. A second change inside the same period separates rate limiting from event loss: it must stay silent until a period pulse and then fire. A simultaneous rise and fall on two bits checks that one event is counted and both polarities are captured. A change made while interrupts are disabled, followed by enabling them, separates "discarded" from "pending". Read strobes taken with interrupts both enabled and disabled confirm that the register can be polled independently.

// File: rtl/fault_pkg.sv
package fault_pkg;
  parameter int unsigned N_FLAGS = 4;
  typedef logic [N_FLAGS-1:0] flag_vec_t;
  typedef enum int unsigned {
    FLT_BUS  = 0,
    FLT_RXD  = 1,
    FLT_TXD  = 2,
    FLT_GND  = 3
  } flag_idx_e;
endpackage

// File: rtl/fault_sync.sv
module fault_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[0] <= '0;
        else         stg_q[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/fault_edge.sv
module fault_edge #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] sync_i,
  output logic [WIDTH-1:0] status_o,
  output logic             evt_o
);
  logic [WIDTH-1:0] status_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) status_q <= '0;
    else         status_q <= sync_i;

  // any bit, either polarity, folded into one event
  assign evt_o    = |(sync_i ^ status_q);
  assign status_o = status_q;

  // R3
  status_change_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(status_q) |-> $past(evt_o));
endmodule

// File: rtl/irq_limiter.sv
module irq_limiter (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic en_i,
  input  logic period_start_i,
  input  logic clr_i,
  output logic irq_o
);
  logic pending_q, used_q, irq_q;
  logic avail, fire;

  assign avail = period_start_i | ~used_q;
  assign fire  = pending_q & avail & en_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      pending_q <= 1'b0;
      used_q    <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      pending_q <= en_i & ((pending_q & ~fire) | evt_i);
      if (fire)                used_q <= 1'b1;
      else if (period_start_i) used_q <= 1'b0;
      if (fire)                irq_q <= 1'b1;   // set wins over clear
      else if (clr_i)          irq_q <= 1'b0;
    end

  assign irq_o = irq_q;

  // R4
  disabled_no_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pending_q);
  // R5
  one_per_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(irq_q) && !$past(period_start_i)) |-> !$past(used_q));
  // R6
  irq_from_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $past(pending_q));
  // R7
  irq_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !clr_i) |=> irq_q);
endmodule

// File: rtl/fault_flag_irq.sv
module fault_flag_irq
  import fault_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_FLAGS-1:0] flags_i,
  input  logic            irq_en_i,
  input  logic            period_start_i,
  input  logic            irq_clr_i,
  input  logic            rd_i,
  output logic [N_FLAGS-1:0] rd_data_o,
  output logic            irq_o,
  input  logic            gnd_lvl_sel_i,
  output logic            gnd_lvl_o
);
  flag_vec_t sync_w, status_w, rd_q;
  logic      evt_w, gnd_q;

  fault_sync #(.WIDTH(N_FLAGS), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .d_i(flags_i), .q_o(sync_w)
  );

  fault_edge #(.WIDTH(N_FLAGS)) i_edge (
    .clk_i, .rst_ni, .sync_i(sync_w), .status_o(status_w), .evt_o(evt_w)
  );

  irq_limiter i_limit (
    .clk_i, .rst_ni, .evt_i(evt_w), .en_i(irq_en_i),
    .period_start_i, .clr_i(irq_clr_i), .irq_o
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      rd_q  <= '0;
      gnd_q <= 1'b0;
    end else begin
      if (rd_i) rd_q <= status_w;
      gnd_q <= gnd_lvl_sel_i;
    end

  assign rd_data_o = rd_q;
  assign gnd_lvl_o = gnd_q;

  // R8
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rd_data_o));
  // R9
  gnd_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnd_lvl_o == $past(gnd_lvl_sel_i));
endmodule

// File: tb/test_fault_flag_irq.sv
module test_fault_flag_irq;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] flags_i = '0;
  logic       irq_en_i = 1'b0, period_start_i = 1'b0, irq_clr_i = 1'b0, rd_i = 1'b0;
  logic       gnd_lvl_sel_i = 1'b0;
  logic [3:0] rd_data_o;
  logic       irq_o, gnd_lvl_o;

  fault_flag_irq i_fault_flag_irq (
    .clk_i, .rst_ni, .flags_i, .irq_en_i, .period_start_i, .irq_clr_i,
    .rd_i, .rd_data_o, .irq_o, .gnd_lvl_sel_i, .gnd_lvl_o
  );

  always #10 clk_i = ~clk_i;  // 50 MHz

  typedef struct {
    string      req;
    int         kind;   // 0 irq, 1 read data, 2 ground level
    logic [3:0] exp;
  } item_t;

  item_t q[$];
  event  chk_ev;
  int    checks = 0, errors = 0;
  bit    done = 1'b0;

  task automatic expect_val(input string req, input int kind, input logic [3:0] exp);
    item_t it;
    it.req = req; it.kind = kind; it.exp = exp;
    q.push_back(it);
    -> chk_ev;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic do_read();
    rd_i = 1'b1; tick(1); rd_i = 1'b0;
  endtask

  task automatic pulse_clr();
    irq_clr_i = 1'b1; tick(1); irq_clr_i = 1'b0;
  endtask

  task automatic pulse_period();
    period_start_i = 1'b1; tick(1); period_start_i = 1'b0;
  endtask

  // monitor: compares queued expectations just after they are posted
  initial forever begin
    @(chk_ev);
    #1;
    while (q.size() > 0) begin
      item_t it;
      logic [3:0] act;
      it = q.pop_front();
      case (it.kind)
        0:       act = {3'b0, irq_o};
        1:       act = rd_data_o;
        default: act = {3'b0, gnd_lvl_o};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind=%0d actual=%b expected=%b", it.req, it.kind, act, it.exp);
      end
    end
  end

  initial begin
    #(20 * 50000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    // R1 reset state
    expect_val("R1", 0, 4'd0);
    expect_val("R1", 1, 4'd0);
    expect_val("R1", 2, 4'd0);
    rst_ni = 1'b1;
    irq_en_i = 1'b1;
    tick(2);

    // R2/R3/R5: rising bus fault, exact latency
    flags_i = 4'b0001;
    tick(3);
    expect_val("R5", 0, 4'd0);
    tick(1);
    expect_val("R5", 0, 4'd1);
    do_read();
    expect_val("R2", 1, 4'b0001);
    // R7 level held
    tick(5);
    expect_val("R7", 0, 4'd1);
    pulse_clr();
    expect_val("R7", 0, 4'd0);

    // R3 falling change inside the used period: suppressed, then R6 pending
    flags_i = 4'b0000;
    tick(8);
    expect_val("R5", 0, 4'd0);
    pulse_period();
    expect_val("R6", 0, 4'd1);
    do_read();
    expect_val("R3", 1, 4'b0000);
    pulse_clr();
    expect_val("R7", 0, 4'd0);
    pulse_period();  // fresh budget, nothing pending

    // R4 disabled: discard
    irq_en_i = 1'b0;
    flags_i = 4'b0110;
    tick(6);
    expect_val("R4", 0, 4'd0);
    do_read();
    expect_val("R8", 1, 4'b0110);
    irq_en_i = 1'b1;
    tick(6);
    expect_val("R4", 0, 4'd0);

    // R3 two bits flip both ways in one cycle: one event
    flags_i = 4'b1010;
    tick(4);
    expect_val("R3", 0, 4'd1);
    // R8 hold without strobe
    expect_val("R8", 1, 4'b0110);
    do_read();
    expect_val("R8", 1, 4'b1010);
    pulse_clr();
    pulse_period();
    tick(4);
    expect_val("R5", 0, 4'd0);

    // R9 ground level select
    gnd_lvl_sel_i = 1'b1;
    tick(1);
    expect_val("R9", 2, 4'd1);
    gnd_lvl_sel_i = 1'b0;
    tick(1);
    expect_val("R9", 2, 4'd0);

    tick(2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule